// File: doc/BRIEF.md
# Cascaded Watchdog Timer with Stop Lock

This block is a watchdog built from two 8-bit down-counters in series. A prescaler divides the enabled input clock by 16 and drives the low counter. The high counter is clocked either by the low counter's underflow (long timeout) or directly by the prescaler output (short timeout). When the high counter underflows, the block issues a one-clock internal reset request. The reset circuit turns that request into a synchronous reset, which it drives back into the block.

After reset the watchdog is idle. The first write of any value to its single control register starts it. Every later write reloads both counters to all ones, clears the prescaler and restarts the timeout from zero. Software must therefore write the register again before the timeout ends.

Bit 7 of the register selects the high counter's clock. Bit 6 is a one-way lock. Once it is set, a pulse on the stop-executed input also raises the reset request. Reading the register returns both control bits and the six most significant bits of the live high counter.

Top module: `casc_watchdog`

## Requirements
- R1: After reset, and until the first write, the counters hold at all ones and no reset request occurs, whatever `clk_en` does. A read returns 0x3F.
- R2: Reset and every write load both counters with all ones and clear the prescaler. A read in the cycle after a write shows 0x3F in bits 5..0.
- R3: A high-counter underflow raises `reset_req` for exactly one clock. It appears on the clock edge that samples the enabled strobe causing the underflow.
- R4: With bit 7 = 1, the high counter decrements once every PRESC_DIV enabled strobes. The request follows the 2^CNT_W × PRESC_DIV-th strobe after a write.
- R5: With bit 7 = 0, the high counter decrements once every 2^CNT_W × PRESC_DIV strobes. The request follows the 2^(2·CNT_W) × PRESC_DIV-th strobe after a write.
- R6: Counting advances only on clocks where `clk_en` is 1. The timeout is measured in enabled strobes, not in clocks.
- R7: Bit 6 (stop lock), once written as 1, stays 1 through later writes of 0.
- R8: With the stop lock at 1, a pulse on `stop_exec` raises `reset_req` on the next clock.
- R9: With the stop lock at 0, a `stop_exec` pulse has no effect, and `reset_req` stays 0.
- R10: A read returns bit 7 = clock select, bit 6 = stop lock, and bits 5..0 = the top six bits of the high counter. Write data in bits 5..0 is ignored.
- R11: If a write and a high-counter underflow occur on the same clock, the write wins. The counters reload and no reset request is issued.
- R12: Reset clears bit 7 and bit 6 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset from the reset circuit, active high |
| clk_en | input | 1 | Input-clock strobe that advances the prescaler |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write data |
| rd_data | output | 8 | Control register read value: {select, lock, high counter top six bits} |
| stop_exec | input | 1 | Pulse: the stop-mode instruction has been executed |
| reset_req | output | 1 | One-clock internal reset request |

## Verification
A wrong count in either counter, or a slip in the prescaler phase, shows in bits 5..0 of the read value. It shows there within one high-counter step: PRESC_DIV strobes in the short mode, or one full low-counter pass in the long mode. It also moves the reset request by one or more strobes away from the arithmetic timeout. A wrong lock or select state shows at once in bits 7..6 of the read value. It also shows in whether a `stop_exec` pulse produces a request on the next clock. A lost write priority shows as a request on the very clock of the reload.

// File: rtl/cwd_pkg.sv
package cwd_pkg;

  localparam int REG_W    = 8;
  localparam int FIELD_W  = 6;
  localparam int SEL_BIT  = 7;
  localparam int LOCK_BIT = 6;

  typedef struct packed {
    logic src_fast;   // 1: high counter clocked by prescaler output
    logic stop_lock;  // 1: stop instruction trips a reset
  } cwd_ctrl_t;

  // Enabled strobes from a reload to the high-counter underflow
  function automatic int unsigned timeout_strobes(input logic fast,
                                                  input int w,
                                                  input int div);
    int unsigned span;
    span = fast ? (32'd1 << w) : (32'd1 << (2 * w));
    return span * div;
  endfunction

  // Down-count with natural wrap to all ones
  function automatic logic [31:0] dec_wrap(input logic [31:0] v, input int w);
    logic [31:0] mask;
    mask = (32'd1 << w) - 32'd1;
    return (v - 32'd1) & mask;
  endfunction

endpackage

// File: rtl/cwd_prescaler.sv
module cwd_prescaler #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  input  logic clk_en,
  output logic tick
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;
  logic          step;

  assign step = run && clk_en;
  assign tick = step && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (step)    cnt <= tick ? '0 : cnt + CW'(1);
  end

  AST_PRESC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!clk_en && !clear) |=> $stable(cnt)); // R6

  AST_PRESC_MOVES: assert property (@(posedge clk) disable iff (rst)
    (run && clk_en && !clear) |=> (cnt != $past(cnt))); // R6

endmodule

// File: rtl/cwd_counters.sv
module cwd_counters #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         tick,
  input  logic         src_fast,
  output logic [W-1:0] cnt_hi,
  output logic         lo_uf,
  output logic         hi_uf
);
  import cwd_pkg::*;

  logic [W-1:0] cnt_lo;
  logic         hi_src;

  assign lo_uf  = tick && (cnt_lo == '0);
  assign hi_src = src_fast ? tick : lo_uf;
  assign hi_uf  = hi_src && (cnt_hi == '0);

  always_ff @(posedge clk) begin
    if (rst || load) begin
      cnt_lo <= '1;
      cnt_hi <= '1;
    end else begin
      if (tick)   cnt_lo <= W'(dec_wrap(32'(cnt_lo), W));
      if (hi_src) cnt_hi <= W'(dec_wrap(32'(cnt_hi), W));
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load) |=> ($stable(cnt_hi) && $stable(cnt_lo))); // R1

  AST_RELOAD_ONES: assert property (@(posedge clk) disable iff (rst)
    load |=> ((cnt_hi == '1) && (cnt_lo == '1))); // R2

endmodule

// File: rtl/cwd_ctrl.sv
module cwd_ctrl (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [7:0]         wr_data,
  output logic               running,
  output cwd_pkg::cwd_ctrl_t ctrl
);
  import cwd_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      running        <= 1'b0;
      ctrl.src_fast  <= 1'b0;
      ctrl.stop_lock <= 1'b0;
    end else if (wr_en) begin
      running        <= 1'b1;
      ctrl.src_fast  <= wr_data[SEL_BIT];
      ctrl.stop_lock <= ctrl.stop_lock | wr_data[LOCK_BIT];
    end
  end

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    ctrl.stop_lock |=> ctrl.stop_lock); // R7

  AST_RUN_STICKY: assert property (@(posedge clk) disable iff (rst)
    running |=> running); // R1

endmodule

// File: rtl/casc_watchdog.sv
module casc_watchdog #(
  parameter int CNT_W     = 8,   // must be at least 6
  parameter int PRESC_DIV = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clk_en,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       stop_exec,
  output logic       reset_req
);
  import cwd_pkg::*;

  logic             running;
  cwd_ctrl_t        ctrl;
  logic             tick;
  logic [CNT_W-1:0] cnt_hi;
  logic             lo_uf;
  logic             hi_uf;
  logic             hi_uf_eff;   // underflow that survives a same-cycle write
  logic             stop_trip;
  logic             req_q;

  cwd_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .running (running),
    .ctrl    (ctrl)
  );

  cwd_prescaler #(.DIV(PRESC_DIV)) u_presc (
    .clk    (clk),
    .rst    (rst),
    .clear  (wr_en),
    .run    (running),
    .clk_en (clk_en),
    .tick   (tick)
  );

  cwd_counters #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (wr_en),
    .tick     (tick),
    .src_fast (ctrl.src_fast),
    .cnt_hi   (cnt_hi),
    .lo_uf    (lo_uf),
    .hi_uf    (hi_uf)
  );

  assign hi_uf_eff = hi_uf && !wr_en;
  assign stop_trip = ctrl.stop_lock && stop_exec;

  always_ff @(posedge clk) begin
    if (rst) req_q <= 1'b0;
    else     req_q <= hi_uf_eff || stop_trip;
  end

  assign reset_req = req_q;
  assign rd_data   = {ctrl.src_fast, ctrl.stop_lock, cnt_hi[CNT_W-1 -: FIELD_W]};

  // Independent strobe counter for timeout checking
  logic [31:0] strobe_cnt;
  always_ff @(posedge clk) begin
    if (rst || wr_en || hi_uf_eff) strobe_cnt <= '0;
    else if (running && clk_en)    strobe_cnt <= strobe_cnt + 32'd1;
  end

  AST_TIMEOUT_EXACT: assert property (@(posedge clk) disable iff (rst)
    hi_uf_eff |-> ((strobe_cnt + 32'd1) ==
                   32'(timeout_strobes(ctrl.src_fast, CNT_W, PRESC_DIV)))); // R4 R5

  AST_UF_REQ: assert property (@(posedge clk) disable iff (rst)
    hi_uf_eff |=> reset_req); // R3

  AST_STOP_TRIP: assert property (@(posedge clk) disable iff (rst)
    (ctrl.stop_lock && stop_exec) |=> reset_req); // R8

  AST_STOP_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.stop_lock && !hi_uf_eff) |=> !reset_req); // R9

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !stop_exec) |=> !reset_req); // R11

  AST_LOW_UF_ONLY_RUNNING: assert property (@(posedge clk) disable iff (rst)
    lo_uf |-> running); // R1

endmodule

// File: tb/casc_watchdog_tb.sv
module casc_watchdog_tb;
  localparam int W   = 6;
  localparam int DIV = 4;
  localparam int T_FAST = (1 << W) * DIV;
  localparam int T_SLOW = (1 << (2 * W)) * DIV;

  logic       clk = 1'b0;
  logic       rst, clk_en, wr_en, stop_exec;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       reset_req;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  casc_watchdog #(.CNT_W(W), .PRESC_DIV(DIV)) u_dut (
    .clk(clk), .rst(rst), .clk_en(clk_en), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .stop_exec(stop_exec), .reset_req(reset_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [5:0] field_after(input int steps);
    return 6'((63 - steps) & 63);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0; stop_exec = 1'b0; clk_en = 1'b1; wr_data = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic write_reg(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    bit seen;
    int strobes;
    rst = 1'b1; clk_en = 1'b0; wr_en = 1'b0; wr_data = '0; stop_exec = 1'b0;
    do_reset();

    // R1 / R12: idle after reset
    chk("R12 reset value", 32'(rd_data), 32'h3F);
    seen = 0;
    for (int i = 0; i < 2000; i++) begin
      clk_en = (i % 2 == 0);
      @(negedge clk);
      if (reset_req) seen = 1;
    end
    chk("R1 idle field", 32'(rd_data), 32'h3F);
    chk("R1 idle no request", 32'(seen), 0);
    clk_en = 1'b1;

    // R4 / R10 / R3: short mode, full sweep of the high counter field
    write_reg(8'h95);
    chk("R2 reload after write", 32'(rd_data), 32'h BF);
    for (int n = 1; n <= T_FAST + 1; n++) begin
      @(negedge clk);
      chk("R4 field", 32'(rd_data[5:0]), 32'(field_after(n / DIV)));
      chk("R3 request timing", 32'(reset_req), 32'(n == T_FAST));
    end
    chk("R10 select bit", 32'(rd_data[7:6]), 32'h2);

    // R11: write on the underflow cycle wins
    write_reg(8'h80);
    repeat (T_FAST - 1) @(negedge clk);
    wr_en = 1'b1; wr_data = 8'h80;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R11 no request", 32'(reset_req), 0);
    chk("R11 reload", 32'(rd_data), 32'hBF);
    for (int n = 1; n <= T_FAST; n++) begin
      @(negedge clk);
      if (n >= T_FAST - 1) chk("R11 next timeout", 32'(reset_req), 32'(n == T_FAST));
    end

    // R6: gated strobes, one in three clocks
    write_reg(8'h80);
    strobes = 0;
    for (int i = 0; i < 3 * T_FAST + 6; i++) begin
      clk_en = (i % 3 == 2);
      if (clk_en) strobes++;
      @(negedge clk);
      chk("R6 gated timeout", 32'(reset_req), 32'(clk_en && strobes == T_FAST));
    end
    clk_en = 1'b1;

    // R5: long mode
    write_reg(8'h00);
    for (int n = 1; n <= T_SLOW + 1; n++) begin
      @(negedge clk);
      chk("R5 request timing", 32'(reset_req), 32'(n == T_SLOW));
      if (n % 64 == 0)
        chk("R5 field", 32'(rd_data[5:0]), 32'(field_after(n / ((1 << W) * DIV))));
    end

    // R9: unlocked stop pulse ignored
    write_reg(8'h00);
    stop_exec = 1'b1;
    @(negedge clk);
    stop_exec = 1'b0;
    chk("R9 stop ignored", 32'(reset_req), 0);
    @(negedge clk);
    chk("R9 stop ignored later", 32'(reset_req), 0);

    // R7 / R8: lock is sticky and trips on stop
    write_reg(8'h40);
    chk("R7 lock set", 32'(rd_data[6]), 1);
    write_reg(8'h00);
    chk("R7 lock kept", 32'(rd_data[6]), 1);
    stop_exec = 1'b1;
    @(negedge clk);
    stop_exec = 1'b0;
    chk("R8 stop trips", 32'(reset_req), 1);
    @(negedge clk);
    chk("R8 one clock", 32'(reset_req), 0);

    // R12: reset clears control bits
    do_reset();
    chk("R12 cleared", 32'(rd_data), 32'h3F);

    done = 1;
    summary();
    $finish;
  end
endmodule